// File: doc/BRIEF.md
# Interleaved DRAM Range Router

This block decides which memory node owns a physical address. It holds eight programmable windows. Each window is a pair of 32-bit registers: a lower-bound word and an upper-bound word. Each window covers a span of the top sixteen address bits, bits 39..24, and names a destination node. A window can be limited to reads, to writes or to both. A window can also take only one lane of a node-interleaved region. The lane is set by comparing address bits 14..12 with a per-window select value, under a mask that the window's interleave code chooses.

A request carries a 40-bit address and a write flag. The result is combinational: a hit flag, the 3-bit node and the index of the window that claimed the request. When several windows claim a request, the lowest index wins. The register port writes on a clock edge, so a change is visible to requests and to readback one cycle later. Software should program a window's upper-bound word before its lower-bound word, because the enables are in the lower-bound word.

Top module: `dram_range_router`

## Requirements
- R1: After reset every register reads zero, and every request misses with hit=0, node_id=0 and range_idx=0.
- R2: The register index is reg_addr[3:1], and reg_addr[0] selects the lower-bound word (0) or the upper-bound word (1). reg_rdata returns the selected word with its reserved bits forced to zero. The lower-bound word keeps bits 31:16, 10:8 and 1:0 (mask 0xFFFF0703). The upper-bound word keeps bits 31:16, 10:8 and 2:0 (mask 0xFFFF0707).
- R3: A window covers an address when lower[31:16] <= addr[39:24] <= upper[31:16]. Both ends are inclusive. A window whose upper bound is below its lower bound covers nothing.
- R4: A read (req_write=0) can only hit a window whose lower[0] is 1. A write (req_write=1) can only hit a window whose lower[1] is 1.
- R5: On a hit, node_id equals upper[2:0] of the winning window.
- R6: The interleave code lower[10:8] picks a lane mask over addr[14:12]. Code 001 checks bit 12 only. Code 011 checks bits 12 and 14. Code 111 checks all three bits. Each checked bit must equal the matching bit of upper[10:8].
- R7: The codes 010, 100, 101 and 110 act like 000: no lane bits are checked.
- R8: When more than one window matches, the lowest index wins. range_idx gives that index.
- R9: When no window matches, or req_valid is 0, the outputs are hit=0, node_id=0 and range_idx=0.
- R10: The outputs follow the request inputs in the same cycle. A register write changes routing and readback only after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | {window index, word select} for write and readback |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register word, reserved bits zero |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | 40 | Physical address of the request |
| hit | output | 1 | A window claimed the request |
| node_id | output | 3 | Destination node of the winning window |
| range_idx | output | 3 | Index of the winning window |

## Verification
A corrupted stored bound, enable or lane field has no effect until a request reaches the window that holds it. It then shows in the same cycle as a wrong hit, node or index, and a readback of that word exposes it in the cycle after the write. A fault in the priority logic only shows when windows overlap, so the sweeps include configurations with heavy overlap and with identical spans that differ only in lane. The same-cycle response and the one-cycle write latency are each checked on both sides of the capturing edge.

// File: rtl/drr_pkg.sv
package drr_pkg;

  parameter int REG_W    = 32;
  parameter int FIELD_W  = 16;
  parameter int NODE_W   = 3;
  parameter int LANE_W   = 3;
  parameter int LANE_LSB = 12;

  localparam logic [REG_W-1:0] LOWER_KEEP = 32'hFFFF_0703;
  localparam logic [REG_W-1:0] UPPER_KEEP = 32'hFFFF_0707;

  typedef struct packed {
    logic [FIELD_W-1:0] lo_bound;
    logic [FIELD_W-1:0] hi_bound;
    logic               rd_ok;
    logic               wr_ok;
    logic [LANE_W-1:0]  lane_code;
    logic [LANE_W-1:0]  lane_sel;
    logic [NODE_W-1:0]  node;
  } window_cfg_t;

  // Lane mask over addr[14:12]; unlisted codes check nothing.
  function automatic logic [LANE_W-1:0] lane_mask(input logic [LANE_W-1:0] code);
    case (code)
      3'b001:  lane_mask = 3'b001;
      3'b011:  lane_mask = 3'b101;
      3'b111:  lane_mask = 3'b111;
      default: lane_mask = 3'b000;
    endcase
  endfunction

  function automatic logic span_covers(input logic [FIELD_W-1:0] field,
                                       input logic [FIELD_W-1:0] lo,
                                       input logic [FIELD_W-1:0] hi);
    span_covers = (field >= lo) && (field <= hi);
  endfunction

  function automatic logic lane_ok(input logic [LANE_W-1:0] lanes,
                                   input logic [LANE_W-1:0] sel,
                                   input logic [LANE_W-1:0] code);
    lane_ok = ((lanes ^ sel) & lane_mask(code)) == '0;
  endfunction

  function automatic window_cfg_t unpack_window(input logic [REG_W-1:0] lower,
                                                input logic [REG_W-1:0] upper);
    window_cfg_t c;
    c.lo_bound  = lower[31:16];
    c.hi_bound  = upper[31:16];
    c.rd_ok     = lower[0];
    c.wr_ok     = lower[1];
    c.lane_code = lower[10:8];
    c.lane_sel  = upper[10:8];
    c.node      = upper[2:0];
    return c;
  endfunction

endpackage

// File: rtl/drr_window_regs.sv
module drr_window_regs
  import drr_pkg::*;
#(
  parameter int NUM_RANGES = 8,
  localparam int IDX_W = $clog2(NUM_RANGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W:0]    sel,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output window_cfg_t       cfg [NUM_RANGES]
);

  logic [REG_W-1:0] lower_q [NUM_RANGES];
  logic [REG_W-1:0] upper_q [NUM_RANGES];
  logic [IDX_W-1:0] win_sel;
  logic             pick_upper;

  assign win_sel    = sel[IDX_W:1];
  assign pick_upper = sel[0];

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lower_q[g] <= '0;
        upper_q[g] <= '0;
      end else if (wr_en && (win_sel == IDX_W'(g))) begin
        if (pick_upper) upper_q[g] <= wdata & UPPER_KEEP;
        else            lower_q[g] <= wdata & LOWER_KEEP;
      end
    end
    assign cfg[g] = unpack_window(lower_q[g], upper_q[g]);
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_RANGES; i++) begin
      if (win_sel == IDX_W'(i)) rdata = pick_upper ? upper_q[i] : lower_q[i];
    end
  end

endmodule

// File: rtl/drr_window_match.sv
module drr_window_match
  import drr_pkg::*;
(
  input  window_cfg_t        cfg,
  input  logic               valid,
  input  logic               is_write,
  input  logic [FIELD_W-1:0] field,
  input  logic [LANE_W-1:0]  lanes,
  output logic               match
);

  logic access_ok;
  assign access_ok = is_write ? cfg.wr_ok : cfg.rd_ok;
  assign match = valid && access_ok
                 && span_covers(field, cfg.lo_bound, cfg.hi_bound)
                 && lane_ok(lanes, cfg.lane_sel, cfg.lane_code);

endmodule

// File: rtl/drr_lowest_pick.sv
module drr_lowest_pick #(
  parameter int NUM_RANGES = 8,
  localparam int IDX_W = $clog2(NUM_RANGES)
) (
  input  logic [NUM_RANGES-1:0] req_vec,
  output logic                  any,
  output logic [IDX_W-1:0]      idx
);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NUM_RANGES - 1; i >= 0; i--) begin
      if (req_vec[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/dram_range_router.sv
module dram_range_router
  import drr_pkg::*;
#(
  parameter int NUM_RANGES = 8,
  parameter int ADDR_W     = 40,
  localparam int IDX_W = $clog2(NUM_RANGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [IDX_W:0]    reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              hit,
  output logic [NODE_W-1:0] node_id,
  output logic [IDX_W-1:0]  range_idx
);

  window_cfg_t         cfg [NUM_RANGES];
  logic [FIELD_W-1:0]  addr_field;
  logic [LANE_W-1:0]   addr_lanes;
  logic [NUM_RANGES-1:0] match_vec;
  logic                any_match;
  logic [IDX_W-1:0]    win_idx;
  logic                unused_addr_bits;

  assign addr_field = req_addr[ADDR_W-1 -: FIELD_W];
  assign addr_lanes = req_addr[LANE_LSB +: LANE_W];
  assign unused_addr_bits = ^{req_addr[ADDR_W-FIELD_W-1:LANE_LSB+LANE_W],
                              req_addr[LANE_LSB-1:0]};

  drr_window_regs #(.NUM_RANGES(NUM_RANGES)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_we),
    .sel   (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .cfg   (cfg)
  );

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_match
    drr_window_match u_match (
      .cfg      (cfg[g]),
      .valid    (req_valid),
      .is_write (req_write),
      .field    (addr_field),
      .lanes    (addr_lanes),
      .match    (match_vec[g])
    );
  end

  drr_lowest_pick #(.NUM_RANGES(NUM_RANGES)) u_pick (
    .req_vec (match_vec),
    .any     (any_match),
    .idx     (win_idx)
  );

  always_comb begin
    hit       = any_match;
    range_idx = any_match ? win_idx : '0;
    node_id   = '0;
    for (int i = 0; i < NUM_RANGES; i++) begin
      if (any_match && (win_idx == IDX_W'(i))) node_id = cfg[i].node;
    end
  end

endmodule

// File: rtl/drr_checker.sv
module drr_checker
  import drr_pkg::*;
#(
  parameter int NUM_RANGES = 8,
  localparam int IDX_W = $clog2(NUM_RANGES)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_we,
  input logic [IDX_W:0]        reg_addr,
  input logic [REG_W-1:0]      reg_wdata,
  input logic [REG_W-1:0]      reg_rdata,
  input logic                  req_valid,
  input logic                  hit,
  input logic [NODE_W-1:0]     node_id,
  input logic [IDX_W-1:0]      range_idx,
  input logic [NUM_RANGES-1:0] match_vec
);

  logic [REG_W-1:0]      keep_now;
  logic [NUM_RANGES-1:0] below_win;

  assign keep_now  = reg_addr[0] ? UPPER_KEEP : LOWER_KEEP;
  assign below_win = (NUM_RANGES'(1) << range_idx) - NUM_RANGES'(1);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~keep_now) == '0);

  assert_write_next_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we ##1 $stable(reg_addr)) |->
      reg_rdata == ($past(reg_wdata) & (reg_addr[0] ? UPPER_KEEP : LOWER_KEEP)));

  assert_hit_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> req_valid);

  assert_miss_outputs_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (node_id == '0 && range_idx == '0));

  assert_hit_tracks_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit == (|match_vec));

  assert_lowest_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (match_vec[range_idx] && ((match_vec & below_win) == '0)));

endmodule

bind dram_range_router drr_checker #(.NUM_RANGES(NUM_RANGES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .req_valid (req_valid),
  .hit       (hit),
  .node_id   (node_id),
  .range_idx (range_idx),
  .match_vec (match_vec)
);

// File: tb/dram_range_router_tb.sv
module dram_range_router_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [39:0] req_addr = '0;
  logic        hit;
  logic [2:0]  node_id;
  logic [2:0]  range_idx;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [31:0] m_lo [8];
  logic [31:0] m_hi [8];
  logic [31:0] lcg = 32'h1234_5678;

  always #4 clk = ~clk;

  dram_range_router u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .hit(hit),
    .node_id(node_id), .range_idx(range_idx)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] keep_of(input bit upper);
    return upper ? 32'hFFFF_0707 : 32'hFFFF_0703;
  endfunction

  // Reference routing computed from the requirement text.
  function automatic logic [31:0] expect_route(input logic v, input logic [39:0] a, input logic w);
    logic [2:0] m;
    logic [15:0] f;
    f = a[39:24];
    if (!v) return 32'h0;
    for (int i = 0; i < 8; i++) begin
      case (m_lo[i][10:8])
        3'd1: m = 3'b001;
        3'd3: m = 3'b101;
        3'd7: m = 3'b111;
        default: m = 3'b000;
      endcase
      if ((w ? m_lo[i][1] : m_lo[i][0]) &&
          f >= m_lo[i][31:16] && f <= m_hi[i][31:16] &&
          ((a[14:12] & m) == (m_hi[i][10:8] & m)))
        return {25'd0, 1'b1, m_hi[i][2:0], 3'(i)};
    end
    return 32'h0;
  endfunction

  task automatic wr_reg(input int idx, input bit upper, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = {3'(idx), upper}; reg_wdata = d;
    if (upper) m_hi[idx] = d & keep_of(1); else m_lo[idx] = d & keep_of(0);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input int idx, input bit upper);
    reg_addr = {3'(idx), upper};
    #1;
    check(tag, reg_rdata, upper ? m_hi[idx] : m_lo[idx]);
  endtask

  task automatic route_chk(input string tag, input logic v, input logic [39:0] a, input logic w);
    req_valid = v; req_addr = a; req_write = w;
    #1;
    check(tag, {25'd0, hit, node_id, range_idx}, expect_route(v, a, w));
  endtask

  function automatic logic [39:0] mk_addr(input logic [15:0] f, input logic [2:0] lane);
    return {f, 9'h15A, lane, 12'hC3F};
  endfunction

  task automatic clear_all();
    for (int i = 0; i < 8; i++) begin
      wr_reg(i, 0, 32'h0);
      wr_reg(i, 1, 32'h0);
    end
  endtask

  task automatic sweep(input string tag);
    for (int f = 0; f < 34; f++)
      for (int l = 0; l < 8; l++)
        for (int w = 0; w < 2; w++)
          route_chk(tag, 1'b1, mk_addr(16'(f), 3'(l)), w[0]);
  endtask

  function automatic logic [31:0] rnd();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg;
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_lo[i] = 0; m_hi[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int i = 0; i < 8; i++) begin rd_chk("R1", i, 0); rd_chk("R1", i, 1); end
    route_chk("R1", 1'b1, mk_addr(16'h0, 3'd0), 1'b0);
    route_chk("R1", 1'b1, mk_addr(16'h0, 3'd0), 1'b1);

    // R2: reserved bits read as zero
    for (int i = 0; i < 8; i++) begin
      wr_reg(i, 1, 32'hFFFF_FFFF); rd_chk("R2", i, 1);
      wr_reg(i, 0, 32'hFFFF_FFFC); rd_chk("R2", i, 0);
    end
    clear_all();

    // R3/R5: inclusive bounds, node from upper word
    wr_reg(2, 1, {16'h0014, 5'd0, 3'd0, 5'd0, 3'd6});
    wr_reg(2, 0, {16'h0010, 16'h0003});
    route_chk("R3", 1'b1, mk_addr(16'h000F, 0), 1'b0);
    route_chk("R3", 1'b1, mk_addr(16'h0010, 0), 1'b0);
    route_chk("R3", 1'b1, mk_addr(16'h0014, 0), 1'b1);
    route_chk("R3", 1'b1, mk_addr(16'h0015, 0), 1'b1);
    route_chk("R5", 1'b1, mk_addr(16'h0012, 5), 1'b0);
    check("R5", {29'd0, node_id}, 32'd6);
    // R9: request not valid
    route_chk("R9", 1'b0, mk_addr(16'h0012, 0), 1'b0);
    check("R9", {29'd0, node_id}, 32'd0);

    // R4: read-only and write-only windows
    wr_reg(0, 1, {16'h0003, 16'h0001});
    wr_reg(0, 0, {16'h0000, 16'h0001});
    wr_reg(1, 1, {16'h0007, 16'h0004});
    wr_reg(1, 0, {16'h0004, 16'h0002});
    wr_reg(3, 1, {16'h001F, 16'h0007});
    wr_reg(3, 0, {16'h0018, 16'h0000});
    route_chk("R4", 1'b1, mk_addr(16'h0002, 0), 1'b0);
    route_chk("R4", 1'b1, mk_addr(16'h0002, 0), 1'b1);
    route_chk("R4", 1'b1, mk_addr(16'h0005, 0), 1'b1);
    route_chk("R4", 1'b1, mk_addr(16'h0005, 0), 1'b0);
    route_chk("R4", 1'b1, mk_addr(16'h001A, 0), 1'b0);
    sweep("R4");

    // R3: upper below lower covers nothing
    clear_all();
    wr_reg(4, 1, {16'h0005, 16'h0002});
    wr_reg(4, 0, {16'h0009, 16'h0003});
    sweep("R3");

    // R8: overlap, lowest index wins
    clear_all();
    wr_reg(5, 1, {16'h0020, 16'h0005});
    wr_reg(5, 0, {16'h0000, 16'h0003});
    wr_reg(1, 1, {16'h0010, 16'h0001});
    wr_reg(1, 0, {16'h0008, 16'h0003});
    route_chk("R8", 1'b1, mk_addr(16'h000A, 0), 1'b0);
    check("R8", {29'd0, range_idx}, 32'd1);
    wr_reg(1, 0, 32'h0);
    route_chk("R8", 1'b1, mk_addr(16'h000A, 0), 1'b0);
    check("R8", {29'd0, range_idx}, 32'd5);
    sweep("R8");

    // R6: eight-way interleave over one span
    clear_all();
    for (int i = 0; i < 8; i++) begin
      wr_reg(i, 1, {16'h001F, 5'd0, 3'(i), 5'd0, 3'(7 - i)});
      wr_reg(i, 0, {16'h0010, 5'd0, 3'b111, 8'h03});
    end
    for (int l = 0; l < 8; l++) begin
      route_chk("R6", 1'b1, mk_addr(16'h0018, 3'(l)), 1'b0);
      check("R6", {29'd0, range_idx}, 32'(l));
    end
    sweep("R6");

    // R6: two-way and four-way lanes
    clear_all();
    wr_reg(0, 1, {16'h001F, 5'd0, 3'b101, 8'h02});
    wr_reg(0, 0, {16'h0000, 5'd0, 3'b011, 8'h03});
    wr_reg(1, 1, {16'h001F, 5'd0, 3'b001, 8'h04});
    wr_reg(1, 0, {16'h0000, 5'd0, 3'b001, 8'h03});
    route_chk("R6", 1'b1, mk_addr(16'h0004, 3'b111), 1'b0);
    check("R6", {29'd0, range_idx}, 32'd0);
    route_chk("R6", 1'b1, mk_addr(16'h0004, 3'b011), 1'b0);
    check("R6", {29'd0, range_idx}, 32'd1);
    sweep("R6");

    // R7: reserved interleave codes ignore lanes
    foreach (m_lo[k]) begin end
    for (int c = 2; c < 7; c++) begin
      if (c == 3) continue;
      clear_all();
      wr_reg(6, 1, {16'h0008, 5'd0, 3'b110, 8'h03});
      wr_reg(6, 0, {16'h0004, 5'd0, 3'(c), 8'h03});
      for (int l = 0; l < 8; l++) begin
        route_chk("R7", 1'b1, mk_addr(16'h0006, 3'(l)), 1'b0);
        check("R7", {28'd0, hit, 3'd0}, 32'h8);
      end
    end

    // R10: write visible only after the capturing edge
    clear_all();
    wr_reg(3, 1, {16'h0030, 16'h0002});
    @(negedge clk);
    reg_we = 1'b1; reg_addr = {3'd3, 1'b0}; reg_wdata = {16'h0020, 16'h0003};
    req_valid = 1'b1; req_addr = mk_addr(16'h0025, 0); req_write = 1'b0;
    #1;
    check("R10", {31'd0, hit}, 32'd0);
    @(posedge clk); #1;
    m_lo[3] = {16'h0020, 16'h0003};
    check("R10", {31'd0, hit}, 32'd1);
    check("R10", {29'd0, node_id}, 32'd2);
    @(negedge clk);
    reg_we = 1'b0;

    // Pseudo-random overlapping configurations
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < 8; i++) begin
        logic [31:0] r1, r2;
        logic [15:0] b, t;
        r1 = rnd(); r2 = rnd();
        b = 16'(r1[20:16] % 32);
        t = (r1[27:25] == 0) ? b - 16'd1 : b + 16'(r1[31:28] % 10);
        wr_reg(i, 1, {t, r2[15:0]});
        wr_reg(i, 0, {b, r2[31:16]});
      end
      sweep("R8");
      for (int i = 0; i < 8; i++) begin rd_chk("R2", i, 0); rd_chk("R2", i, 1); end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule